// File: doc/BRIEF.md
# Character LCD Parallel Bus Engine

This block sits on the host side of a character LCD controller and turns single requests from a valid/ready port into complete bus cycles on the controller's parallel interface. Each request is one of three kinds: a write to the instruction register, a write to the data register, or a read of the status byte. For every bus transfer the engine sets the register-select and read/write lines, waits out a setup interval, raises the enable strobe for a fixed number of clocks, and keeps all lines steady for a recovery interval after enable falls. Every interval is a parameter counted in system clocks.

The bus width is chosen per request. In narrow mode a byte goes out as two transfers on the upper four data lines, high half first, with the lower four lines driven low; reads are put back together the same way. On a read cycle the engine never drives the data lines. After every write it either reads the status byte repeatedly until the busy bit clears and then waits a guard interval, or it just waits a fixed time that suits the instruction. Which of the two it does is fixed at build time. A status read asked for by the host is returned on a one-cycle response strobe.

Top module: `lcd_bus_engine`

## Requirements
- R1: `req_kind_i` codes are 2'b00 instruction write (RS=0, R/W=0), 2'b01 data write (RS=1, R/W=0), and 2'b10 or 2'b11 status read (RS=0, R/W=1).
- R2: RS, R/W and the driven data are unchanged for at least T_SETUP clocks before E rises and are still unchanged at E's fall. E stays high for exactly T_EHIGH clocks. E stays low for at least T_CYCLE-T_EHIGH clocks before each rise.
- R3: With `req_nibble_i`=0 a write byte goes out on DB7..DB0 (bit 7 on `lcd_db_o[7]`) in one transfer.
- R4: With `req_nibble_i`=1 each byte takes two transfers on `lcd_db_o[7:4]`, bits 7..4 first and bits 3..0 second, with `lcd_db_o[3:0]`=0. A read takes its first nibble from `lcd_db_i[7:4]` as result bits 7..4 and its second as bits 3..0.
- R5: `lcd_db_oe_o` is low whenever R/W is high. `lcd_db_i` is sampled on the last clock of E high. A status read ends with a one-cycle `rsp_valid_o` that carries the whole byte, busy flag in bit 7.
- R6: With POLL_BUSY=1, each write is followed by status reads, repeated while bit 7 of the result is 1. `req_ready_o` stays low until polling ends.
- R7: With POLL_BUSY=1, after the status read that returns bit 7 = 0, E stays low for at least T_GAP clocks before the next rise.
- R8: With POLL_BUSY=0, no status read follows a write. The engine waits WAIT_LONG clocks after instruction bytes 8'h01 to 8'h03 and WAIT_SHORT clocks after any other write, and only then raises `req_ready_o`.
- R9: While reset is applied: `req_ready_o`=1, E=0, `lcd_db_oe_o`=0 and `rsp_valid_o`=0.
- R10: E is low whenever `req_ready_o` is high. A status read requested by the host is followed by no extra bus cycles or wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Engine idle and accepting a request |
| req_kind_i | input | 2 | Request kind (see R1) |
| req_data_i | input | 8 | Byte to write |
| req_nibble_i | input | 1 | 1 selects the 4-bit bus for this request |
| rsp_valid_o | output | 1 | Status byte valid, one cycle |
| rsp_data_o | output | 8 | Status byte read back |
| lcd_rs_o | output | 1 | Register select |
| lcd_rw_o | output | 1 | Read (1) / write (0) |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data bus value to drive |
| lcd_db_oe_o | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus value from the controller |

## Verification
The assertions take for granted that the timing parameters are all at least one and that T_EHIGH covers the controller's read output delay. They also take for granted that the host holds a request steady while it waits for ready, and that the controller changes `lcd_db_i` only when E is low. The bench's panel model drives the data lines only while R/W is high, and it moves from one nibble to the next or updates its busy count only at a falling edge of E. The bench raises a request only at a clock's falling edge and holds it until the request is accepted.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_WAIT
  } seq_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // clear and home style instructions need the long execution wait
  function automatic logic is_slow_instr(input logic [7:0] b);
    return (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
  endfunction

endpackage

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
  import lcd_bus_pkg::*;
#(
  parameter int unsigned T_SETUP = 10,
  parameter int unsigned T_EHIGH = 30,
  parameter int unsigned T_LOW   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] lane_i,
  output logic       done_o,
  output logic [7:0] sample_o,
  output logic       e_o,
  output logic       rs_o,
  output logic       rw_o,
  output logic [7:0] db_o,
  output logic       db_oe_o,
  input  logic [7:0] db_i
);

  localparam int unsigned TMAX = umax(umax(T_SETUP, T_EHIGH), T_LOW);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          rs_q, rw_q, done_q;
  logic [7:0]    lane_q, smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rs_q   <= 1'b0;
      rw_q   <= 1'b0;
      lane_q <= '0;
      smp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q   <= PH_SETUP;
            cnt_q  <= CW'(T_SETUP - 1);
            rs_q   <= rs_i;
            rw_q   <= rw_i;
            lane_q <= lane_i;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_HIGH;
            cnt_q <= CW'(T_EHIGH - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == '0) begin
            smp_q <= db_i;  // read delay covered by E high width
            ph_q  <= PH_HOLD;
            cnt_q <= CW'(T_LOW - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign sample_o = smp_q;
  assign e_o      = (ph_q == PH_HIGH);
  assign rs_o     = rs_q;
  assign rw_o     = rw_q;
  assign db_o     = lane_q;
  assign db_oe_o  = (ph_q != PH_IDLE) && !rw_q;

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         idle_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter bit          POLL_BUSY  = 1'b1,
  parameter int unsigned T_SETUP    = 10,
  parameter int unsigned T_EHIGH    = 30,
  parameter int unsigned T_HOLD     = 2,
  parameter int unsigned T_CYCLE    = 50,
  parameter int unsigned T_GAP      = 185,
  parameter int unsigned WAIT_SHORT = 4300,
  parameter int unsigned WAIT_LONG  = 153000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [1:0] req_kind_i,
  input  logic [7:0] req_data_i,
  input  logic       req_nibble_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_db_o,
  output logic       lcd_db_oe_o,
  input  logic [7:0] lcd_db_i
);

  // low time after E falls, stretched so the whole E cycle meets T_CYCLE
  localparam int unsigned T_LOW =
    (T_CYCLE > T_EHIGH + T_SETUP + T_HOLD) ? (T_CYCLE - T_EHIGH - T_SETUP) : T_HOLD;
  localparam int unsigned WW = $clog2(umax(umax(WAIT_LONG, WAIT_SHORT), T_GAP) + 1);

  seq_e          sq_q;
  logic          m4_q, rd_q, rs_q, poll_q, nib_q;
  logic [7:0]    byte_q, rsp_q;
  logic [3:0]    hi_q;
  logic          start_q, rsp_valid_q, tmr_load_q;
  logic [WW-1:0] tmr_val_q;

  logic          xf_done, tmr_idle;
  logic [7:0]    xf_smp, lane, got;
  logic          xf_rs, xf_rw;

  always_comb begin
    if (m4_q) lane = {(nib_q ? byte_q[3:0] : byte_q[7:4]), 4'b0000};
    else      lane = byte_q;
  end

  assign got   = m4_q ? {hi_q, xf_smp[7:4]} : xf_smp;
  assign xf_rs = poll_q ? 1'b0 : rs_q;
  assign xf_rw = poll_q | rd_q;

  // per-write wait after the last transfer of the byte
  logic [WW-1:0] post_wait;
  generate
    if (POLL_BUSY) begin : g_poll
      assign post_wait = WW'(T_GAP);
    end else begin : g_fixed
      assign post_wait = is_slow_instr(byte_q) && !rs_q ? WW'(WAIT_LONG) : WW'(WAIT_SHORT);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q        <= SQ_IDLE;
      m4_q        <= 1'b0;
      rd_q        <= 1'b0;
      rs_q        <= 1'b0;
      poll_q      <= 1'b0;
      nib_q       <= 1'b0;
      byte_q      <= '0;
      hi_q        <= '0;
      rsp_q       <= '0;
      start_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      tmr_load_q  <= 1'b0;
      tmr_val_q   <= '0;
    end else begin
      start_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      tmr_load_q  <= 1'b0;
      unique case (sq_q)
        SQ_IDLE: begin
          if (req_valid_i) begin
            m4_q    <= req_nibble_i;
            rd_q    <= req_kind_i[1];
            rs_q    <= !req_kind_i[1] && req_kind_i[0];
            byte_q  <= req_data_i;
            nib_q   <= 1'b0;
            poll_q  <= 1'b0;
            start_q <= 1'b1;
            sq_q    <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (xf_done) begin
            if (m4_q && !nib_q) begin
              hi_q    <= xf_smp[7:4];
              nib_q   <= 1'b1;
              start_q <= 1'b1;
            end else begin
              nib_q <= 1'b0;
              if (poll_q) begin
                if (got[7]) begin
                  start_q <= 1'b1;
                end else begin
                  poll_q     <= 1'b0;
                  tmr_load_q <= 1'b1;
                  tmr_val_q  <= post_wait;
                  sq_q       <= SQ_WAIT;
                end
              end else if (rd_q) begin
                rsp_q       <= got;
                rsp_valid_q <= 1'b1;
                sq_q        <= SQ_IDLE;
              end else if (POLL_BUSY) begin
                poll_q  <= 1'b1;
                start_q <= 1'b1;
              end else begin
                tmr_load_q <= 1'b1;
                tmr_val_q  <= post_wait;
                sq_q       <= SQ_WAIT;
              end
            end
          end
        end
        SQ_WAIT: begin
          if (!tmr_load_q && tmr_idle) sq_q <= SQ_IDLE;
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  lcd_strobe_gen #(
    .T_SETUP (T_SETUP),
    .T_EHIGH (T_EHIGH),
    .T_LOW   (T_LOW)
  ) u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_q),
    .rs_i     (xf_rs),
    .rw_i     (xf_rw),
    .lane_i   (lane),
    .done_o   (xf_done),
    .sample_o (xf_smp),
    .e_o      (lcd_e_o),
    .rs_o     (lcd_rs_o),
    .rw_o     (lcd_rw_o),
    .db_o     (lcd_db_o),
    .db_oe_o  (lcd_db_oe_o),
    .db_i     (lcd_db_i)
  );

  lcd_wait_timer #(.W(WW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load_q),
    .val_i  (tmr_val_q),
    .idle_o (tmr_idle)
  );

  assign req_ready_o = (sq_q == SQ_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_q;

endmodule

// File: rtl/lcd_bus_engine_chk.sv
module lcd_bus_engine_chk #(
  parameter int unsigned T_SETUP = 10,
  parameter int unsigned T_EHIGH = 30,
  parameter int unsigned T_CYCLE = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       lcd_rs_o,
  input logic       lcd_rw_o,
  input logic       lcd_e_o,
  input logic [7:0] lcd_db_o,
  input logic       lcd_db_oe_o
);

  localparam int unsigned LO_MIN = (T_CYCLE > T_EHIGH) ? (T_CYCLE - T_EHIGH) : 0;

  logic [15:0] hi_cnt, lo_cnt, stab_cnt;
  logic [9:0]  sig_prev;
  logic [9:0]  sig_now;

  assign sig_now = {lcd_rs_o, lcd_rw_o, lcd_db_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      lo_cnt   <= '1;
      stab_cnt <= '1;
      sig_prev <= '0;
    end else begin
      sig_prev <= sig_now;
      if (lcd_e_o) begin
        hi_cnt <= hi_cnt + 1'b1;
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
      if (sig_now != sig_prev) stab_cnt <= 16'd1;
      else if (stab_cnt != '1) stab_cnt <= stab_cnt + 1'b1;
    end
  end

  AST_E_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> (32'(hi_cnt) == T_EHIGH)); // R2

  AST_E_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> (32'(lo_cnt) >= LO_MIN)); // R2

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> (32'(stab_cnt) >= T_SETUP)); // R2

  AST_STABLE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> ($stable(lcd_rs_o) && $stable(lcd_rw_o) && $stable(lcd_db_o))); // R2

  AST_READ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o |-> !lcd_db_oe_o); // R5

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R5

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_e_o); // R10

endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(
  .T_SETUP (T_SETUP),
  .T_EHIGH (T_EHIGH),
  .T_CYCLE (T_CYCLE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .lcd_rs_o    (lcd_rs_o),
  .lcd_rw_o    (lcd_rw_o),
  .lcd_e_o     (lcd_e_o),
  .lcd_db_o    (lcd_db_o),
  .lcd_db_oe_o (lcd_db_oe_o)
);

// File: tb/lcd_bus_engine_tb.sv
module lcd_panel_model (
  input  logic       clk,
  input  logic       e,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_o,
  input  logic       oe,
  output logic [7:0] db_i
);
  int         busy_left = 0;
  bit         m4 = 1'b0;
  bit         ph = 1'b0;
  int         n_ent = 0;
  logic [7:0] ent_byte [64];
  bit         ent_rs [64];
  bit         ent_rw [64];
  int         ent_low [64];
  int         min_setup = 1000000;
  int         min_high = 1000000;
  int         max_high = 0;
  int         n_oe_bad = 0;
  int         n_nib_bad = 0;
  int         hcnt = 0, lo = 1000, stab = 1000, cur_low = 0;
  bit         e_prev = 1'b0;
  logic [10:0] sig_prev = '0;
  logic [3:0] hi_nib = '0;
  logic [7:0] stat;

  assign stat = {(busy_left > 0), 7'h25};
  assign db_i = !rw ? 8'h00 : (m4 ? (ph ? {stat[3:0], 4'h0} : {stat[7:4], 4'h0}) : stat);

  task automatic log_ent(input bit r_s, input bit r_w, input logic [7:0] b);
    if (n_ent < 64) begin
      ent_byte[n_ent] = b;
      ent_rs[n_ent]   = r_s;
      ent_rw[n_ent]   = r_w;
      ent_low[n_ent]  = cur_low;
    end
    n_ent++;
  endtask

  always @(negedge clk) begin
    logic [10:0] sig;
    sig = {rs, rw, oe, db_o};
    if (rw && oe) n_oe_bad++;
    if (e && !e_prev) begin
      if (stab < min_setup) min_setup = stab;
      if (!ph) cur_low = lo;
    end
    if (!e && e_prev) begin
      if (hcnt < min_high) min_high = hcnt;
      if (hcnt > max_high) max_high = hcnt;
      if (rw) begin
        if (m4 && !ph) ph = 1'b1;
        else begin
          ph = 1'b0;
          log_ent(rs, 1'b1, stat);
          if (busy_left > 0) busy_left--;
        end
      end else begin
        if (m4 && !ph) begin
          hi_nib = db_o[7:4];
          if (db_o[3:0] != 4'h0) n_nib_bad++;
          ph = 1'b1;
        end else if (m4) begin
          if (db_o[3:0] != 4'h0) n_nib_bad++;
          ph = 1'b0;
          log_ent(rs, 1'b0, {hi_nib, db_o[7:4]});
        end else begin
          log_ent(rs, 1'b0, db_o);
        end
      end
    end
    if (e) begin hcnt++; lo = 0; end
    else begin hcnt = 0; lo++; end
    if (sig != sig_prev) stab = 1; else stab++;
    e_prev = e;
    sig_prev = sig;
  end
endmodule

module lcd_bus_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TS = 2, TH = 4, THD = 1, TC = 9, TG = 6, WS = 20, WL = 60;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       v0 = 1'b0, v1 = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [7:0] data = 8'h00;
  logic       nib = 1'b0;
  bit         sel = 1'b0;

  logic       rdy0, rsv0, rs0, rw0, e0, oe0;
  logic [7:0] rsd0, dbo0, dbi0;
  logic       rdy1, rsv1, rs1, rw1, e1, oe1;
  logic [7:0] rsd1, dbo1, dbi1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rsp_got;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_bus_engine #(.POLL_BUSY(1'b1), .T_SETUP(TS), .T_EHIGH(TH), .T_HOLD(THD),
    .T_CYCLE(TC), .T_GAP(TG), .WAIT_SHORT(WS), .WAIT_LONG(WL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v0), .req_ready_o(rdy0),
    .req_kind_i(kind), .req_data_i(data), .req_nibble_i(nib),
    .rsp_valid_o(rsv0), .rsp_data_o(rsd0), .lcd_rs_o(rs0), .lcd_rw_o(rw0),
    .lcd_e_o(e0), .lcd_db_o(dbo0), .lcd_db_oe_o(oe0), .lcd_db_i(dbi0));

  lcd_bus_engine #(.POLL_BUSY(1'b0), .T_SETUP(TS), .T_EHIGH(TH), .T_HOLD(THD),
    .T_CYCLE(TC), .T_GAP(TG), .WAIT_SHORT(WS), .WAIT_LONG(WL)) u_fix (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v1), .req_ready_o(rdy1),
    .req_kind_i(kind), .req_data_i(data), .req_nibble_i(nib),
    .rsp_valid_o(rsv1), .rsp_data_o(rsd1), .lcd_rs_o(rs1), .lcd_rw_o(rw1),
    .lcd_e_o(e1), .lcd_db_o(dbo1), .lcd_db_oe_o(oe1), .lcd_db_i(dbi1));

  lcd_panel_model u_mdl  (.clk(clk), .e(e0), .rs(rs0), .rw(rw0), .db_o(dbo0), .oe(oe0), .db_i(dbi0));
  lcd_panel_model u_mdl2 (.clk(clk), .e(e1), .rs(rs1), .rw(rw1), .db_o(dbo1), .oe(oe1), .db_i(dbi1));

  function automatic logic rdy();
    return sel ? rdy1 : rdy0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] d, input logic n4);
    @(negedge clk);
    kind = k; data = d; nib = n4;
    if (sel) v1 = 1'b1; else v0 = 1'b1;
    while (!rdy()) @(negedge clk);
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
  endtask

  // cycles from acceptance until ready again; captures any response byte
  task automatic wait_ready(output int cyc);
    cyc = 1;
    while (!rdy() && cyc < 5000) begin
      @(negedge clk);
      if ((sel ? rsv1 : rsv0)) rsp_got = sel ? rsd1 : rsd0;
      cyc++;
    end
  endtask

  task automatic t_reset();
    #(CLK_PERIOD*2 + 1);
    check(rdy0 && !e0 && !oe0 && !rsv0, "R9 reset outputs",
          {28'd0, rdy0, e0, oe0, rsv0}, 8);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_poll8();
    int b, c;
    sel = 0; b = u_mdl.n_ent; u_mdl.busy_left = 3;
    issue(2'b00, 8'h38, 1'b0);
    check(!rdy0, "R6 ready low while polling", int'(rdy0), 0);
    wait_ready(c);
    check(u_mdl.n_ent - b == 5, "R6 poll count", u_mdl.n_ent - b, 5);
    check(!u_mdl.ent_rs[b] && !u_mdl.ent_rw[b] && u_mdl.ent_byte[b] == 8'h38,
          "R1 R3 instr write", int'(u_mdl.ent_byte[b]), 'h38);
    check(u_mdl.ent_rw[b+1] && u_mdl.ent_byte[b+1] == 8'hA5, "R6 busy poll",
          int'(u_mdl.ent_byte[b+1]), 'hA5);
    check(u_mdl.ent_byte[b+4] == 8'h25 && !u_mdl.ent_rs[b+4], "R6 final poll",
          int'(u_mdl.ent_byte[b+4]), 'h25);
    issue(2'b01, 8'h41, 1'b0);
    wait_ready(c);
    check(u_mdl.ent_rs[b+5] && !u_mdl.ent_rw[b+5] && u_mdl.ent_byte[b+5] == 8'h41,
          "R1 R3 data write", int'(u_mdl.ent_byte[b+5]), 'h41);
    check(u_mdl.ent_low[b+5] >= TG + TS, "R7 gap after flag clear",
          u_mdl.ent_low[b+5], TG + TS);
    check(u_mdl.n_ent - b == 7, "R6 single poll when idle", u_mdl.n_ent - b, 7);
  endtask

  task automatic t_stat8();
    int b, c;
    sel = 0; b = u_mdl.n_ent; u_mdl.busy_left = 1; rsp_got = 8'h00;
    issue(2'b10, 8'h00, 1'b0);
    wait_ready(c);
    check(rsp_got == 8'hA5, "R5 status busy", int'(rsp_got), 'hA5);
    check(u_mdl.n_ent - b == 1 && u_mdl.ent_rw[b] && !u_mdl.ent_rs[b],
          "R10 R1 status read single cycle", u_mdl.n_ent - b, 1);
    issue(2'b11, 8'h00, 1'b0);
    wait_ready(c);
    check(rsp_got == 8'h25, "R5 status idle", int'(rsp_got), 'h25);
  endtask

  task automatic t_nib4();
    int b, c;
    sel = 0; u_mdl.m4 = 1'b1; b = u_mdl.n_ent; u_mdl.busy_left = 1;
    issue(2'b00, 8'h28, 1'b1);
    wait_ready(c);
    check(u_mdl.ent_byte[b] == 8'h28 && !u_mdl.ent_rw[b], "R4 nibble order write",
          int'(u_mdl.ent_byte[b]), 'h28);
    check(u_mdl.n_nib_bad == 0, "R4 low lanes zero", u_mdl.n_nib_bad, 0);
    check(u_mdl.n_ent - b == 3 && u_mdl.ent_byte[b+1] == 8'hA5, "R4 R6 nibble poll",
          u_mdl.n_ent - b, 3);
    u_mdl.busy_left = 1;
    issue(2'b10, 8'h00, 1'b1);
    wait_ready(c);
    check(rsp_got == 8'hA5, "R4 nibble read assembly", int'(rsp_got), 'hA5);
    issue(2'b01, 8'hC3, 1'b1);
    wait_ready(c);
    check(u_mdl.ent_byte[b+4] == 8'hC3 && u_mdl.ent_rs[b+4], "R4 nibble data write",
          int'(u_mdl.ent_byte[b+4]), 'hC3);
    u_mdl.m4 = 1'b0;
  endtask

  task automatic t_timing();
    check(u_mdl.min_high == TH && u_mdl.max_high == TH, "R2 E high width",
          u_mdl.min_high, TH);
    check(u_mdl.min_setup >= TS, "R2 setup before rise", u_mdl.min_setup, TS);
    check(u_mdl.n_oe_bad == 0, "R5 bus released on reads", u_mdl.n_oe_bad, 0);
  endtask

  task automatic t_fixed();
    int b, c;
    sel = 1; b = u_mdl2.n_ent;
    issue(2'b00, 8'h01, 1'b0);
    wait_ready(c);
    check(c >= WL, "R8 long wait clear", c, WL);
    check(u_mdl2.n_ent - b == 1, "R8 no status polling", u_mdl2.n_ent - b, 1);
    issue(2'b00, 8'h0C, 1'b0);
    wait_ready(c);
    check(c >= WS && c < WL, "R8 short wait instr", c, WS);
    issue(2'b01, 8'h02, 1'b0);
    wait_ready(c);
    check(c >= WS && c < WL, "R8 short wait data", c, WS);
    check(u_mdl2.ent_byte[b+2] == 8'h02 && u_mdl2.ent_rs[b+2], "R1 R8 data write",
          int'(u_mdl2.ent_byte[b+2]), 'h02);
    issue(2'b00, 8'h03, 1'b0);
    wait_ready(c);
    check(c >= WL, "R8 long wait home", c, WL);
    sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_poll8();
    t_stat8();
    t_nib4();
    t_timing();
    t_fixed();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule